// File: doc/BRIEF.md
# Receive Descriptor Ring Pointer Manager

This block tracks the three positions that matter on one receive descriptor ring: the tail, the head and the current pointer. The tail marks where software has stopped posting empty descriptors. The head marks the next descriptor that hardware will read from host memory into its prefetch buffer. The current pointer marks the oldest descriptor still held in that buffer. All three are offsets counted in descriptors. Each offset carries a 2-bit lap identifier that steps on every wrap, so equal offsets can be told apart as "full" or "empty".

Software posts descriptors only by writing a tail increment. The prefetch logic reports how many descriptors it fetched, and the packet path reports how many it consumed. The block clips every advance to what the ring actually holds. A tail increment larger than the free space is clipped and raises a sticky error. The block also turns the head offset into a byte address, using a 16-byte-aligned ring base.

Configuration arrives as single-cycle register writes, and a selector picks the target: ring length, tail increment, control bits or base address. Every pointer, count and flag comes straight from registered state, so a write or strobe shows at the outputs one clock after the edge that samples it.

Top module: `rp_desc_ring_ptr`

## Requirements
- R1: After reset all three pointers have offset 0 and lap identifier 0, the ring length is RST_LEN, the base is 0, the error flag is 0, and the used count, available count and full flag are all 0.
- R2: Each pointer word carries the offset in bits 23:0 and the lap identifier in bits 31:30; bits 29:24 read 0.
- R3: A write with selector 1 adds cfg_data_i[23:0] descriptors to the tail. An offset that reaches the ring length wraps by subtracting the length, and its lap identifier increments modulo 4 (3 goes to 0).
- R4: A tail increment is clipped to the free space (ring length minus used count). A request larger than the free space sets inc_err_o, which stays set until a queue reset.
- R5: A fetch strobe advances the head by min(fetch_cnt_i, available count), with the same wrap rule as R3.
- R6: A consume strobe advances the current pointer by min(consume_cnt_i, distance from current to head), with the same wrap rule.
- R7: used_cnt_o is the ring distance from current to tail, and avail_cnt_o is the ring distance from head to tail. Both take the lap identifiers into account, so a distance can equal the full ring length.
- R8: ring_full_o is 1 exactly when head and tail have equal offsets and different lap identifiers.
- R9: A write with selector 0 sets the ring length to cfg_data_i[23:0]. A value of 0 is ignored.
- R10: A write with selector 3 sets the base to cfg_data_i with bits 3:0 forced to 0. fetch_addr_o equals the base plus 16 times the head offset.
- R11: A write with selector 2 applies these control bits. Bit 3 moves the head back to the current pointer (prefetch flush). Bit 0 zeroes the tail, bit 1 zeroes the head and bit 2 zeroes the current pointer. Bit 4 zeroes all three and clears the error flag. The bits apply in that order, and they override fetch or consume strobes in the same cycle.
- R12: A pointer keeps its value in any cycle in which no strobe or write targets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write target: 0 length, 1 tail increment, 2 control, 3 base |
| cfg_data_i | input | 32 | Write data |
| fetch_vld_i | input | 1 | Descriptors were fetched into the prefetch buffer |
| fetch_cnt_i | input | CNT_W | Number fetched |
| consume_vld_i | input | 1 | Descriptors were consumed from the prefetch buffer |
| consume_cnt_i | input | CNT_W | Number consumed |
| tail_ptr_o | output | 32 | Tail pointer word |
| head_ptr_o | output | 32 | Head pointer word |
| cur_ptr_o | output | 32 | Current pointer word |
| used_cnt_o | output | 24 | Descriptors posted and not yet consumed |
| avail_cnt_o | output | 24 | Descriptors posted and not yet fetched |
| ring_full_o | output | 1 | Head and tail are one lap apart |
| inc_err_o | output | 1 | Sticky flag: a tail increment was clipped |
| fetch_addr_o | output | 32 | Byte address of the descriptor at the head |

## Verification
The embedded assertions check four things on every cycle. A pointer does not move in a cycle with no strobe or write aimed at it. The error flag stays set until a control write. The error flag rises only after a tail-increment write. The head never runs past the tail. The bench's scenarios are needed for the rest, which depends on sequences: lap identifiers wrapping from 3 to 0, the clipping amounts, the full flag after exactly one lap, a length write of 0 being ignored, and control-bit priority over a strobe in the same cycle. A seeded random mix of increments, fetches and consumes on a short ring covers clipping and wrapping together, checked against a bench model.

// File: rtl/rp_pkg.sv
package rp_pkg;
    localparam int OFS_W   = 24;
    localparam int RID_W   = 2;
    localparam int REG_W   = 32;
    localparam int ALIGN_W = 4;
    localparam int POS_W   = OFS_W + RID_W;
    localparam int NPTR    = 3;

    localparam int IDX_TAIL = 0;
    localparam int IDX_HEAD = 1;
    localparam int IDX_CUR  = 2;

    localparam int CTL_TAIL_RST  = 0;
    localparam int CTL_HEAD_RST  = 1;
    localparam int CTL_CUR_RST   = 2;
    localparam int CTL_FLUSH     = 3;
    localparam int CTL_QUEUE_RST = 4;

    typedef enum logic [1:0] {
        SEL_LEN      = 2'd0,
        SEL_TAIL_INC = 2'd1,
        SEL_CTRL     = 2'd2,
        SEL_BASE     = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [RID_W-1:0] rid;
        logic [OFS_W-1:0] ofs;
    } ring_ptr_t;

    function automatic logic [REG_W-1:0] pack_ptr(ring_ptr_t p);
        logic [REG_W-1:0] w;
        w = '0;
        w[REG_W-1 -: RID_W] = p.rid;
        w[OFS_W-1:0]        = p.ofs;
        return w;
    endfunction
endpackage

// File: rtl/rp_ring_adv.sv
module rp_ring_adv
    import rp_pkg::*;
(
    input  ring_ptr_t        ptr_i,
    input  logic [OFS_W-1:0] step_i,
    input  logic [OFS_W-1:0] len_i,
    output ring_ptr_t        ptr_o
);
    logic [OFS_W:0] sum_w;
    logic [OFS_W:0] wrap_w;

    always_comb begin
        sum_w  = {1'b0, ptr_i.ofs} + {1'b0, step_i};
        wrap_w = sum_w - {1'b0, len_i};
        if (sum_w >= {1'b0, len_i}) begin
            ptr_o.ofs = wrap_w[OFS_W-1:0];
            ptr_o.rid = ptr_i.rid + RID_W'(1);
        end else begin
            ptr_o.ofs = sum_w[OFS_W-1:0];
            ptr_o.rid = ptr_i.rid;
        end
    end
endmodule

// File: rtl/rp_ring_dist.sv
module rp_ring_dist
    import rp_pkg::*;
(
    input  ring_ptr_t        from_i,
    input  ring_ptr_t        to_i,
    input  logic [OFS_W-1:0] len_i,
    output logic [POS_W-1:0] dist_o
);
    logic [POS_W-1:0] pos_from;
    logic [POS_W-1:0] pos_to;
    logic [POS_W-1:0] span;

    always_comb begin
        pos_from = POS_W'(from_i.rid) * POS_W'(len_i) + POS_W'(from_i.ofs);
        pos_to   = POS_W'(to_i.rid)   * POS_W'(len_i) + POS_W'(to_i.ofs);
        span     = POS_W'(len_i) << RID_W;
        if (pos_to >= pos_from) begin
            dist_o = pos_to - pos_from;
        end else begin
            dist_o = (span - pos_from) + pos_to;
        end
    end
endmodule

// File: rtl/rp_desc_ring_ptr.sv
module rp_desc_ring_ptr
    import rp_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int RST_LEN = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_wr_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [REG_W-1:0]  cfg_data_i,
    input  logic              fetch_vld_i,
    input  logic [CNT_W-1:0]  fetch_cnt_i,
    input  logic              consume_vld_i,
    input  logic [CNT_W-1:0]  consume_cnt_i,
    output logic [REG_W-1:0]  tail_ptr_o,
    output logic [REG_W-1:0]  head_ptr_o,
    output logic [REG_W-1:0]  cur_ptr_o,
    output logic [OFS_W-1:0]  used_cnt_o,
    output logic [OFS_W-1:0]  avail_cnt_o,
    output logic              ring_full_o,
    output logic              inc_err_o,
    output logic [REG_W-1:0]  fetch_addr_o
);
    localparam int BASE_W = REG_W - ALIGN_W;

    typedef struct packed {
        ring_ptr_t          tail;
        ring_ptr_t          head;
        ring_ptr_t          cur;
        logic [OFS_W-1:0]   len;
        logic [BASE_W-1:0]  base;
        logic               err;
    } state_t;

    state_t state_d, state_q;

    ring_ptr_t        adv_in   [NPTR];
    ring_ptr_t        adv_out  [NPTR];
    logic [OFS_W-1:0] adv_step [NPTR];
    ring_ptr_t        dist_from[NPTR];
    ring_ptr_t        dist_to  [NPTR];
    logic [POS_W-1:0] dist_w   [NPTR];

    // distance pairs: 0 cur->tail (used), 1 head->tail (avail), 2 cur->head (held)
    assign dist_from[0] = state_q.cur;
    assign dist_to[0]   = state_q.tail;
    assign dist_from[1] = state_q.head;
    assign dist_to[1]   = state_q.tail;
    assign dist_from[2] = state_q.cur;
    assign dist_to[2]   = state_q.head;

    assign adv_in[IDX_TAIL] = state_q.tail;
    assign adv_in[IDX_HEAD] = state_q.head;
    assign adv_in[IDX_CUR]  = state_q.cur;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        rp_ring_adv u_adv (
            .ptr_i  (adv_in[g]),
            .step_i (adv_step[g]),
            .len_i  (state_q.len),
            .ptr_o  (adv_out[g])
        );
        rp_ring_dist u_dist (
            .from_i (dist_from[g]),
            .to_i   (dist_to[g]),
            .len_i  (state_q.len),
            .dist_o (dist_w[g])
        );
    end

    logic             wr_len, wr_tail, wr_ctrl, wr_base;
    logic [OFS_W-1:0] free_w;
    logic [OFS_W-1:0] tail_req;
    logic             tail_over;

    assign wr_len  = cfg_wr_i && (cfg_sel_i == SEL_LEN);
    assign wr_tail = cfg_wr_i && (cfg_sel_i == SEL_TAIL_INC);
    assign wr_ctrl = cfg_wr_i && (cfg_sel_i == SEL_CTRL);
    assign wr_base = cfg_wr_i && (cfg_sel_i == SEL_BASE);
    assign tail_req = cfg_data_i[OFS_W-1:0];

    // step sizes, each clipped to what the ring holds
    always_comb begin
        if (dist_w[0] >= POS_W'(state_q.len)) begin
            free_w = '0;
        end else begin
            free_w = state_q.len - dist_w[0][OFS_W-1:0];
        end
        tail_over = 1'b0;
        adv_step[IDX_TAIL] = '0;
        if (wr_tail) begin
            if (tail_req > free_w) begin
                adv_step[IDX_TAIL] = free_w;
                tail_over          = 1'b1;
            end else begin
                adv_step[IDX_TAIL] = tail_req;
            end
        end
        adv_step[IDX_HEAD] = '0;
        if (fetch_vld_i) begin
            if (POS_W'(fetch_cnt_i) > dist_w[1]) adv_step[IDX_HEAD] = dist_w[1][OFS_W-1:0];
            else                                 adv_step[IDX_HEAD] = OFS_W'(fetch_cnt_i);
        end
        adv_step[IDX_CUR] = '0;
        if (consume_vld_i) begin
            if (POS_W'(consume_cnt_i) > dist_w[2]) adv_step[IDX_CUR] = dist_w[2][OFS_W-1:0];
            else                                   adv_step[IDX_CUR] = OFS_W'(consume_cnt_i);
        end
    end

    // next state
    always_comb begin
        state_d      = state_q;
        state_d.tail = adv_out[IDX_TAIL];
        state_d.head = adv_out[IDX_HEAD];
        state_d.cur  = adv_out[IDX_CUR];
        if (tail_over) state_d.err = 1'b1;
        if (wr_len && (cfg_data_i[OFS_W-1:0] != '0)) begin
            state_d.len = cfg_data_i[OFS_W-1:0];
        end
        if (wr_base) state_d.base = cfg_data_i[REG_W-1:ALIGN_W];
        if (wr_ctrl) begin
            if (cfg_data_i[CTL_FLUSH])    state_d.head = state_d.cur;
            if (cfg_data_i[CTL_TAIL_RST]) state_d.tail = '0;
            if (cfg_data_i[CTL_HEAD_RST]) state_d.head = '0;
            if (cfg_data_i[CTL_CUR_RST])  state_d.cur  = '0;
            if (cfg_data_i[CTL_QUEUE_RST]) begin
                state_d.tail = '0;
                state_d.head = '0;
                state_d.cur  = '0;
                state_d.err  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q      <= '0;
            state_q.len  <= OFS_W'(RST_LEN);
        end else begin
            state_q <= state_d;
        end
    end

    assign tail_ptr_o   = pack_ptr(state_q.tail);
    assign head_ptr_o   = pack_ptr(state_q.head);
    assign cur_ptr_o    = pack_ptr(state_q.cur);
    assign used_cnt_o   = dist_w[0][OFS_W-1:0];
    assign avail_cnt_o  = dist_w[1][OFS_W-1:0];
    assign ring_full_o  = (state_q.head.ofs == state_q.tail.ofs) &&
                          (state_q.head.rid != state_q.tail.rid);
    assign inc_err_o    = state_q.err;
    assign fetch_addr_o = {state_q.base, {ALIGN_W{1'b0}}} +
                          (REG_W'(state_q.head.ofs) << ALIGN_W);

    // R12
    head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fetch_vld_i && !cfg_wr_i) |=> $stable(head_ptr_o));
    // R12
    tail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_wr_i) |=> $stable(tail_ptr_o));
    // R12
    cur_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!consume_vld_i && !cfg_wr_i) |=> $stable(cur_ptr_o));
    // R4
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_err_o && !(cfg_wr_i && cfg_sel_i == SEL_CTRL)) |=> inc_err_o);
    // R4
    err_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(inc_err_o) |-> $past(cfg_wr_i && cfg_sel_i == SEL_TAIL_INC));
    // R5
    head_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fetch_vld_i && !cfg_wr_i && avail_cnt_o == '0) |=> $stable(head_ptr_o));
endmodule

// File: tb/rp_desc_ring_ptr_tb.sv
`timescale 1ns/1ps
module rp_desc_ring_ptr_tb;
    localparam int CNT_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_data = '0;
    logic        fetch_vld = 1'b0;
    logic [7:0]  fetch_cnt = '0;
    logic        consume_vld = 1'b0;
    logic [7:0]  consume_cnt = '0;
    logic [31:0] tail_ptr, head_ptr, cur_ptr, fetch_addr;
    logic [23:0] used_cnt, avail_cnt;
    logic        ring_full, inc_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model
    int m_tr, m_to, m_hr, m_ho, m_cr, m_co, m_len, m_base, m_err;

    always #5 clk = ~clk;

    rp_desc_ring_ptr #(.CNT_W(CNT_W), .RST_LEN(16)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
        .fetch_vld_i(fetch_vld), .fetch_cnt_i(fetch_cnt),
        .consume_vld_i(consume_vld), .consume_cnt_i(consume_cnt),
        .tail_ptr_o(tail_ptr), .head_ptr_o(head_ptr), .cur_ptr_o(cur_ptr),
        .used_cnt_o(used_cnt), .avail_cnt_o(avail_cnt),
        .ring_full_o(ring_full), .inc_err_o(inc_err), .fetch_addr_o(fetch_addr)
    );

    function automatic int ring_dist(int rf, int of_, int rt, int ot, int len);
        int pf, pt, span;
        span = 4 * len;
        pf = rf * len + of_;
        pt = rt * len + ot;
        return (pt - pf + span) % span;
    endfunction

    function automatic int min2(int a, int b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [31:0] ptr_word(int rid, int ofs);
        logic [31:0] w;
        w = '0;
        w[31:30] = rid[1:0];
        w[23:0]  = ofs[23:0];
        return w;
    endfunction

    task automatic adv(inout int rid, inout int ofs, input int n, input int len);
        int s;
        s = ofs + n;
        if (s >= len) begin
            ofs = s - len;
            rid = (rid + 1) % 4;
        end else begin
            ofs = s;
        end
    endtask

    task automatic model_reset();
        m_tr = 0; m_to = 0; m_hr = 0; m_ho = 0; m_cr = 0; m_co = 0;
        m_len = 16; m_base = 0; m_err = 0;
    endtask

    task automatic model_step(bit wr, int sel, logic [31:0] data,
                              bit fv, int fc, bit cv, int cc);
        int used, avail, held, free, inc;
        used  = ring_dist(m_cr, m_co, m_tr, m_to, m_len);
        avail = ring_dist(m_hr, m_ho, m_tr, m_to, m_len);
        held  = ring_dist(m_cr, m_co, m_hr, m_ho, m_len);
        free  = (used >= m_len) ? 0 : m_len - used;
        if (wr && sel == 1) begin
            inc = int'(data[23:0]);
            if (inc > free) m_err = 1;
            adv(m_tr, m_to, min2(inc, free), m_len);
        end
        if (fv) adv(m_hr, m_ho, min2(fc, avail), m_len);
        if (cv) adv(m_cr, m_co, min2(cc, held), m_len);
        if (wr && sel == 0 && data[23:0] != 0) m_len = int'(data[23:0]);
        if (wr && sel == 3) m_base = int'({data[31:4], 4'b0});
        if (wr && sel == 2) begin
            if (data[3]) begin m_hr = m_cr; m_ho = m_co; end
            if (data[0]) begin m_tr = 0; m_to = 0; end
            if (data[1]) begin m_hr = 0; m_ho = 0; end
            if (data[2]) begin m_cr = 0; m_co = 0; end
            if (data[4]) begin
                m_tr = 0; m_to = 0; m_hr = 0; m_ho = 0; m_cr = 0; m_co = 0; m_err = 0;
            end
        end
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [31:0] e_addr;
        e_addr = 32'(m_base) + 32'(m_ho * 16);
        chk(tag, "tail_ptr", tail_ptr, ptr_word(m_tr, m_to));
        chk(tag, "head_ptr", head_ptr, ptr_word(m_hr, m_ho));
        chk(tag, "cur_ptr",  cur_ptr,  ptr_word(m_cr, m_co));
        chk(tag, "used_cnt", 32'(used_cnt), 32'(ring_dist(m_cr, m_co, m_tr, m_to, m_len)));
        chk(tag, "avail_cnt", 32'(avail_cnt), 32'(ring_dist(m_hr, m_ho, m_tr, m_to, m_len)));
        chk(tag, "ring_full", 32'(ring_full), 32'((m_ho == m_to) && (m_hr != m_tr)));
        chk(tag, "inc_err", 32'(inc_err), 32'(m_err));
        chk(tag, "fetch_addr", fetch_addr, e_addr);
    endtask

    // called at a negative edge; applies one cycle of stimulus and checks after it
    task automatic op(string tag, bit wr, int sel, logic [31:0] data,
                      bit fv, int fc, bit cv, int cc);
        cfg_wr = wr; cfg_sel = sel[1:0]; cfg_data = data;
        fetch_vld = fv; fetch_cnt = fc[7:0];
        consume_vld = cv; consume_cnt = cc[7:0];
        model_step(wr, sel, data, fv, fc[7:0], cv, cc[7:0]);
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; fetch_vld = 1'b0; consume_vld = 1'b0;
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 R2: reset state and word format
        check_all("R1");
        op("R12", 0, 0, 0, 0, 0, 0, 0);

        // R9: zero length ignored, shown by clipping at the old length 16
        op("R9", 1, 0, 32'h0, 0, 0, 0, 0);
        op("R4", 1, 1, 32'd20, 0, 0, 0, 0);
        op("R11", 1, 2, 32'h10, 0, 0, 0, 0);
        op("R9", 1, 0, 32'd13, 0, 0, 0, 0);

        // R3 R5 R6: full laps, lap id wraps 3 -> 0
        for (int lap = 0; lap < 5; lap++) begin
            op("R3", 1, 1, 32'd13, 0, 0, 0, 0);
            op("R8", 0, 0, 0, 0, 0, 0, 0);
            op("R5", 0, 0, 0, 1, 13, 0, 0);
            op("R6", 0, 0, 0, 0, 0, 1, 13);
        end

        // R8 full, then R4 clip while full
        op("R8", 1, 1, 32'd13, 0, 0, 0, 0);
        op("R4", 1, 1, 32'd1, 0, 0, 0, 0);
        op("R4", 0, 0, 0, 1, 2, 0, 0);
        op("R11", 1, 2, 32'h10, 0, 0, 0, 0);

        // R10 base alignment and address
        op("R10", 1, 3, 32'h1234_567F, 0, 0, 0, 0);
        op("R3", 1, 1, 32'd7, 0, 0, 0, 0);
        op("R10", 0, 0, 0, 1, 3, 0, 0);
        // R5 R6 clipping beyond what is held
        op("R5", 0, 0, 0, 1, 200, 1, 50);
        op("R6", 0, 0, 0, 0, 0, 1, 255);
        op("R7", 1, 1, 32'd4, 0, 0, 0, 0);
        op("R5", 0, 0, 0, 1, 2, 0, 0);
        // R11 flush, then priority of a head reset over a same-cycle fetch
        op("R11", 1, 2, 32'h8, 0, 0, 0, 0);
        op("R11", 1, 2, 32'h7, 1, 3, 1, 1);
        op("R11", 1, 1, 32'd5, 0, 0, 0, 0);
        op("R11", 1, 2, 32'h1, 0, 0, 0, 0);
        op("R12", 0, 0, 0, 0, 0, 0, 0);

        // random mix on the 13-entry ring
        for (int i = 0; i < 600; i++) begin
            int k;
            bit wr, fv, cv;
            int sel, fc, cc;
            logic [31:0] data;
            k = int'($urandom_range(0, 99));
            wr = ($urandom_range(0, 2) == 0);
            sel = 1;
            data = 32'($urandom_range(0, 9));
            if (k < 5) data = 32'($urandom_range(10, 30));
            if (k == 99) begin sel = 2; data = 32'h10; end
            else if (k == 98) begin sel = 2; data = 32'h8; end
            fv = ($urandom_range(0, 1) == 1);
            cv = ($urandom_range(0, 1) == 1);
            fc = int'($urandom_range(0, 8));
            cc = int'($urandom_range(0, 8));
            op("R7", wr, sel, data, fv, fc, cv, cc);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule